// File: doc/BRIEF.md
# Three-Dimensional Transfer Parameter Sequencer

This block keeps the working copy of one channel's transfer parameters. The parameters are source and destination start addresses, bytes per array, arrays per frame, frames per block, and signed steps between arrays and between frames, kept separately for source and destination. The copy also holds a synchronization mode, a completion mode, a 6-bit completion code and a 16-bit link pointer. On each trigger the block turns this copy into one transfer-request descriptor for an external executor. It then advances its addresses and counts. In array-synchronized mode one trigger covers one array. In frame-synchronized mode one trigger covers a whole frame.

When the last request of a set has gone out, the working copy is replaced by the entry of a small parameter memory that the link pointer selects. This keeps repeated or circular transfers going without outside help. Empty sets are never issued. An all-zero set is left in place, and a partly-zero set is replaced through its link. Completion is reported either when the request is issued or when the executor returns a code on `exec_done`/`exec_code`.

Top module: `xfer_param_seq`

## Requirements
- R1: After reset no request and no completion are presented, and the working set is all zero, so a trigger then yields only a completion with code 0.
- R2: In array mode (`ab_mode` = 0) each trigger issues one descriptor with `req_arrays` = 1 and `req_acnt` = the set's byte count; inside a frame the next source and destination starts are the previous ones plus the signed array steps. A set needs arrays x frames triggers.
- R3: In array mode, after the last array of a frame, the frame step is added to the start of that last array to give the first array of the next frame.
- R4: In frame mode (`ab_mode` = 1) each trigger issues one descriptor with `req_arrays` = the set's array count; after it, the frame step is added to the start of that frame's first array. A set needs frame-count triggers.
- R5: After the final request of a set, the working set is loaded from the memory entry whose index equals the 16-bit link field; an index of DEPTH or above loads an all-zero set.
- R6: A trigger on a set whose three counts are all zero issues nothing, produces a completion carrying that set's code, and leaves the set unchanged.
- R7: A trigger on a set with at least one zero count and at least one nonzero count issues nothing, produces a completion carrying its code, and reloads through its link. No descriptor ever has a zero byte or array count.
- R8: With early completion (`early` = 1) the completion carrying `req_code` appears in the same cycle as the descriptor.
- R9: With normal completion (`early` = 0) nothing is reported at issue time; an `exec_done` pulse with `exec_code` gives a completion with that code one cycle later.
- R10: When a local completion (early, dummy or null) and an executor return fall due in the same cycle, the local one is reported first and the returned one in the following cycle.
- R11: `bind_load` loads the working set from memory entry `bind_idx`; a trigger in the same cycle is dropped.
- R12: Address arithmetic wraps modulo 2^32, with signed 16-bit steps.
- R13: A descriptor appears in the cycle after the clock edge that samples `trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_we | input | 1 | Write parameter memory entry `mem_idx` |
| mem_idx | input | 16 | Memory entry index for a write |
| mem_wdata | input | 200 | Parameter set, laid out as `seq_pkg::pset_t` |
| bind_load | input | 1 | Load the working set from entry `bind_idx` |
| bind_idx | input | 16 | Entry to load |
| trig | input | 1 | Synchronization event |
| exec_done | input | 1 | Executor finished a normal-mode request |
| exec_code | input | 6 | Code returned with `exec_done` |
| req_valid | output | 1 | Descriptor valid for one cycle |
| req_src | output | 32 | Source start address |
| req_dst | output | 32 | Destination start address |
| req_acnt | output | 16 | Bytes per array |
| req_arrays | output | 16 | Arrays in this request |
| req_src_bidx | output | 16 | Signed source step between arrays |
| req_dst_bidx | output | 16 | Signed destination step between arrays |
| req_code | output | 6 | Completion code |
| req_early | output | 1 | Request uses early completion |
| done_valid | output | 1 | Completion reported |
| done_code | output | 6 | Code of the reported completion |

## Verification
A descriptor and any early, dummy or null completion tied to it are due exactly one edge after the edge that samples `trig`. An executor return is due one edge after `exec_done`, or two edges after it when a local completion takes the same slot. The reference model predicts both outputs at the same edge the inputs are sampled, and the compare runs on the falling edge, where the registered outputs of that edge have settled. The model computes addresses from the set's base, the frame number and the array number, not by stepping them, so an error in the frame-step update point shows up as a different address.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int ADDR_W = 32;
   localparam int CNT_W  = 16;
   localparam int IDX_W  = 16;
   localparam int LINK_W = 16;
   localparam int CODE_W = 6;

   typedef struct packed {
      logic [ADDR_W-1:0]        src;
      logic [ADDR_W-1:0]        dst;
      logic [CNT_W-1:0]         acnt;
      logic [CNT_W-1:0]         bcnt;
      logic [CNT_W-1:0]         ccnt;
      logic signed [IDX_W-1:0]  sbidx;
      logic signed [IDX_W-1:0]  dbidx;
      logic signed [IDX_W-1:0]  scidx;
      logic signed [IDX_W-1:0]  dcidx;
      logic [LINK_W-1:0]        link;
      logic                     ab_mode;
      logic                     early;
      logic [CODE_W-1:0]        code;
   } pset_t;

   localparam int SET_W = $bits(pset_t);

   function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                   input logic signed [IDX_W-1:0] d);
      return a + {{(ADDR_W-IDX_W){d[IDX_W-1]}}, d};
   endfunction
endpackage

// File: rtl/seq_param_mem.sv
module seq_param_mem
   import seq_pkg::*;
#(
   parameter int DEPTH          = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LINK_W-1:0] waddr,
   input  pset_t             wdata,
   input  logic [LINK_W-1:0] raddr,
   output pset_t             rdata
);
   localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   pset_t ent [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         pset_t q;
         if (CLEAR_ON_RESET) begin : g_clr
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                          q <= '0;
               else if (we && waddr == LINK_W'(g))  q <= wdata;
            end
         end else begin : g_keep
            always_ff @(posedge clk) begin
               if (we && waddr == LINK_W'(g)) q <= wdata;
            end
         end
         assign ent[g] = q;
      end
   endgenerate

   always_comb begin
      if (32'(raddr) < DEPTH) rdata = ent[raddr[SEL_W-1:0]];
      else                    rdata = '0;
   end
endmodule

// File: rtl/seq_step.sv
module seq_step
   import seq_pkg::*;
(
   input  pset_t            cur,
   input  logic [CNT_W-1:0] b_left,
   output pset_t            nxt,
   output logic [CNT_W-1:0] nxt_b_left,
   output logic             last,
   output logic [CNT_W-1:0] arrays
);
   logic frame_end;

   always_comb begin
      nxt        = cur;
      nxt_b_left = b_left;
      frame_end  = cur.ab_mode || (b_left <= CNT_W'(1));
      last       = frame_end && (cur.ccnt == CNT_W'(1));
      arrays     = cur.ab_mode ? cur.bcnt : CNT_W'(1);
      if (frame_end) begin
         // frame step from the current start: first array (frame mode)
         // or last array of the frame (array mode)
         nxt.src    = step_addr(cur.src, cur.scidx);
         nxt.dst    = step_addr(cur.dst, cur.dcidx);
         nxt.ccnt   = cur.ccnt - CNT_W'(1);
         nxt_b_left = cur.bcnt;
      end else begin
         nxt.src    = step_addr(cur.src, cur.sbidx);
         nxt.dst    = step_addr(cur.dst, cur.dbidx);
         nxt_b_left = b_left - CNT_W'(1);
      end
   end
endmodule

// File: rtl/seq_cmpl_merge.sv
module seq_cmpl_merge
   import seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_v,
   input  logic [CODE_W-1:0] loc_code,
   input  logic              ret_v,
   input  logic [CODE_W-1:0] ret_code,
   output logic              done_v,
   output logic [CODE_W-1:0] done_code
);
   logic              hold_v;
   logic [CODE_W-1:0] hold_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_v    <= 1'b0;
         done_code <= '0;
         hold_v    <= 1'b0;
         hold_code <= '0;
      end else begin
         done_v <= 1'b0;
         if (loc_v) begin
            done_v    <= 1'b1;
            done_code <= loc_code;
            if (ret_v) begin
               hold_v    <= 1'b1;
               hold_code <= ret_code;
            end
         end else if (hold_v) begin
            done_v    <= 1'b1;
            done_code <= hold_code;
            hold_v    <= ret_v;
            if (ret_v) hold_code <= ret_code;
         end else if (ret_v) begin
            done_v    <= 1'b1;
            done_code <= ret_code;
         end
      end
   end
endmodule

// File: rtl/xfer_param_seq.sv
module xfer_param_seq
   import seq_pkg::*;
#(
   parameter int DEPTH          = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_we,
   input  logic [LINK_W-1:0] mem_idx,
   input  logic [SET_W-1:0]  mem_wdata,
   input  logic              bind_load,
   input  logic [LINK_W-1:0] bind_idx,
   input  logic              trig,
   input  logic              exec_done,
   input  logic [CODE_W-1:0] exec_code,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_src,
   output logic [ADDR_W-1:0] req_dst,
   output logic [CNT_W-1:0]  req_acnt,
   output logic [CNT_W-1:0]  req_arrays,
   output logic [IDX_W-1:0]  req_src_bidx,
   output logic [IDX_W-1:0]  req_dst_bidx,
   output logic [CODE_W-1:0] req_code,
   output logic              req_early,
   output logic              done_valid,
   output logic [CODE_W-1:0] done_code
);
   generate
      if (DEPTH < 2 || DEPTH > 4096) begin : g_bad_depth
         $error("xfer_param_seq: DEPTH out of range");
      end
   endgenerate

   pset_t             act_q, rd_set, nxt_set, wr_set;
   logic [CNT_W-1:0]  b_left_q, nxt_b_left, arrays;
   logic [LINK_W-1:0] rd_idx;
   logic              last, issuable, all_zero, fire, loc_v;

   assign wr_set = pset_t'(mem_wdata);
   assign rd_idx = bind_load ? bind_idx : act_q.link;

   seq_param_mem #(.DEPTH(DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_idx), .wdata(wr_set),
      .raddr(rd_idx), .rdata(rd_set));

   seq_step u_step (
      .cur(act_q), .b_left(b_left_q), .nxt(nxt_set), .nxt_b_left(nxt_b_left),
      .last(last), .arrays(arrays));

   always_comb begin
      issuable = (act_q.acnt != '0) && (act_q.bcnt != '0) && (act_q.ccnt != '0);
      all_zero = (act_q.acnt == '0) && (act_q.bcnt == '0) && (act_q.ccnt == '0);
      fire     = trig && !bind_load;
      loc_v    = fire && (!issuable || act_q.early);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q        <= '0;
         b_left_q     <= '0;
         req_valid    <= 1'b0;
         req_src      <= '0;
         req_dst      <= '0;
         req_acnt     <= '0;
         req_arrays   <= '0;
         req_src_bidx <= '0;
         req_dst_bidx <= '0;
         req_code     <= '0;
         req_early    <= 1'b0;
      end else begin
         req_valid <= 1'b0;
         if (bind_load) begin
            act_q    <= rd_set;
            b_left_q <= rd_set.bcnt;
         end else if (fire && issuable) begin
            req_valid    <= 1'b1;
            req_src      <= act_q.src;
            req_dst      <= act_q.dst;
            req_acnt     <= act_q.acnt;
            req_arrays   <= arrays;
            req_src_bidx <= act_q.sbidx;
            req_dst_bidx <= act_q.dbidx;
            req_code     <= act_q.code;
            req_early    <= act_q.early;
            if (last) begin
               act_q    <= rd_set;
               b_left_q <= rd_set.bcnt;
            end else begin
               act_q    <= nxt_set;
               b_left_q <= nxt_b_left;
            end
         end else if (fire && !all_zero) begin
            act_q    <= rd_set;
            b_left_q <= rd_set.bcnt;
         end
      end
   end

   seq_cmpl_merge u_merge (
      .clk(clk), .rst_n(rst_n), .loc_v(loc_v), .loc_code(act_q.code),
      .ret_v(exec_done), .ret_code(exec_code), .done_v(done_valid),
      .done_code(done_code));
endmodule

// File: rtl/seq_checker.sv
module seq_checker
   import seq_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              trig,
   input logic              bind_load,
   input logic              ab_mode,
   input logic              req_valid,
   input logic              req_early,
   input logic [CNT_W-1:0]  req_acnt,
   input logic [CNT_W-1:0]  req_arrays,
   input logic [CODE_W-1:0] req_code,
   input logic              done_valid,
   input logic [CODE_W-1:0] done_code
);
   a_r13_req_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(trig));

   a_r11_bind_drops_trig: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bind_load) |-> !req_valid);

   a_r7_no_empty_desc: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_acnt != '0 && req_arrays != '0));

   a_r8_early_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_early) |-> (done_valid && done_code == req_code));

   a_r2_one_array: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !$past(ab_mode)) |-> (req_arrays == CNT_W'(1)));
endmodule

bind xfer_param_seq seq_checker u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .bind_load(bind_load),
   .ab_mode(act_q.ab_mode), .req_valid(req_valid), .req_early(req_early),
   .req_acnt(req_acnt), .req_arrays(req_arrays), .req_code(req_code),
   .done_valid(done_valid), .done_code(done_code));

// File: tb/tb_xfer_param_seq.sv
module tb_xfer_param_seq;
   import seq_pkg::*;

   localparam int NSET = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mem_we = 1'b0;
   logic [15:0]       mem_idx = '0;
   logic [SET_W-1:0]  mem_wdata = '0;
   logic              bind_load = 1'b0;
   logic [15:0]       bind_idx = '0;
   logic              trig = 1'b0;
   logic              exec_done = 1'b0;
   logic [5:0]        exec_code = '0;
   logic              req_valid, req_early, done_valid;
   logic [31:0]       req_src, req_dst;
   logic [15:0]       req_acnt, req_arrays, req_src_bidx, req_dst_bidx;
   logic [5:0]        req_code, done_code;

   xfer_param_seq dut (.*);

   always #2.5 clk = ~clk;

   int    vectors = 0;
   int    miscompares = 0;
   int    cycles = 0;
   string tag = "R1";

   // reference model state
   pset_t mmem [NSET];
   pset_t mset;
   int    k;
   int    qret [$];
   logic        e_rv, e_early, e_dv;
   logic [31:0] e_src, e_dst;
   logic [15:0] e_acnt, e_arr, e_sb, e_db;
   logic [5:0]  e_code, e_dcode;

   function automatic pset_t rd(input logic [15:0] i);
      if (int'(i) < NSET) return mmem[i[2:0]];
      return '0;
   endfunction

   task automatic load_set(input pset_t s);
      mset = s;
      k = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSET; i++) mmem[i] = '0;
         mset = '0; k = 0; qret.delete();
         e_rv = 0; e_dv = 0; e_dcode = '0;
      end else begin
         logic loc;
         logic [5:0] lcode;
         int f, j, total, nb;
         loc = 0; lcode = '0; e_rv = 0;
         if (bind_load) load_set(rd(bind_idx));
         else if (trig) begin
            if (mset.acnt == 0 && mset.bcnt == 0 && mset.ccnt == 0) begin
               loc = 1; lcode = mset.code;
            end else if (mset.acnt == 0 || mset.bcnt == 0 || mset.ccnt == 0) begin
               loc = 1; lcode = mset.code; load_set(rd(mset.link));
            end else begin
               nb = int'(mset.bcnt);
               if (mset.ab_mode) begin
                  f = k; j = 0; total = int'(mset.ccnt);
                  e_src = mset.src + f * int'($signed(mset.scidx));
                  e_dst = mset.dst + f * int'($signed(mset.dcidx));
                  e_arr = mset.bcnt;
               end else begin
                  f = k / nb; j = k % nb; total = nb * int'(mset.ccnt);
                  e_src = mset.src + f * ((nb - 1) * int'($signed(mset.sbidx)) + int'($signed(mset.scidx)))
                          + j * int'($signed(mset.sbidx));
                  e_dst = mset.dst + f * ((nb - 1) * int'($signed(mset.dbidx)) + int'($signed(mset.dcidx)))
                          + j * int'($signed(mset.dbidx));
                  e_arr = 16'd1;
               end
               e_rv = 1; e_acnt = mset.acnt; e_sb = mset.sbidx; e_db = mset.dbidx;
               e_code = mset.code; e_early = mset.early;
               if (mset.early) begin loc = 1; lcode = mset.code; end
               k++;
               if (k == total) load_set(rd(mset.link));
            end
         end
         if (mem_we && int'(mem_idx) < NSET) mmem[mem_idx[2:0]] = pset_t'(mem_wdata);
         e_dv = 0;
         if (exec_done) qret.push_back(int'(exec_code));
         if (loc) begin
            e_dv = 1; e_dcode = lcode;
         end else if (qret.size() > 0) begin
            e_dv = 1; e_dcode = 6'(qret.pop_front());
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         vectors++;
         if (req_valid !== e_rv ||
             (e_rv && (req_src !== e_src || req_dst !== e_dst || req_acnt !== e_acnt ||
                       req_arrays !== e_arr || req_src_bidx !== e_sb || req_dst_bidx !== e_db ||
                       req_code !== req_code || req_code !== e_code || req_early !== e_early))) begin
            miscompares++;
            $display("FAIL %s request: got v=%0d src=%h dst=%h acnt=%0d arr=%0d code=%0d exp v=%0d src=%h dst=%h acnt=%0d arr=%0d code=%0d",
                     tag, req_valid, req_src, req_dst, req_acnt, req_arrays, req_code,
                     e_rv, e_src, e_dst, e_acnt, e_arr, e_code);
         end
         if (done_valid !== e_dv || (e_dv && done_code !== e_dcode)) begin
            miscompares++;
            $display("FAIL %s completion: got v=%0d code=%0d exp v=%0d code=%0d",
                     tag, done_valid, done_code, e_dv, e_dcode);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         miscompares++;
         $display("FAIL watchdog: got %0d cycles exp under 20000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_set(input int idx, input pset_t s);
      @(negedge clk);
      mem_we = 1; mem_idx = 16'(idx); mem_wdata = s;
      @(negedge clk);
      mem_we = 0;
   endtask

   task automatic drive(input logic t, input logic b, input int bi, input logic e, input int ec);
      @(negedge clk);
      trig = t; bind_load = b; bind_idx = 16'(bi); exec_done = e; exec_code = 6'(ec);
      @(negedge clk);
      trig = 0; bind_load = 0; exec_done = 0;
   endtask

   task automatic kick(input int gap);
      drive(1, 0, 0, 0, 0);
      idle(gap);
   endtask

   function automatic pset_t mk(input logic [31:0] s, input logic [31:0] d,
                                input int a, input int b, input int c,
                                input int sb, input int db, input int sc, input int dc,
                                input int lk, input logic ab, input logic er, input int cd);
      pset_t p;
      p.src = s; p.dst = d; p.acnt = 16'(a); p.bcnt = 16'(b); p.ccnt = 16'(c);
      p.sbidx = 16'(sb); p.dbidx = 16'(db); p.scidx = 16'(sc); p.dcidx = 16'(dc);
      p.link = 16'(lk); p.ab_mode = ab; p.early = er; p.code = 6'(cd);
      return p;
   endfunction

   initial begin
      idle(3);
      rst_n = 1;
      // R1 R6: reset state, trigger on the all-zero set gives only completion code 0
      tag = "R1"; idle(3);
      kick(2);
      tag = "setup";
      put_set(0, mk(32'h1000, 32'h8000, 8, 4, 3, 16, 32, 256, -64, 1, 0, 1, 5));
      put_set(1, mk(32'h10, 32'h2000, 16, 4, 3, 64, -16, -64, 768, 2, 1, 0, 9));
      put_set(2, mk(32'h0, 32'h0, 4, 0, 2, 0, 0, 0, 0, 3, 0, 0, 3));
      put_set(3, mk(32'h0, 32'h0, 0, 0, 0, 0, 0, 0, 0, 5, 0, 1, 42));
      put_set(4, mk(32'hFFFF_FFF0, 32'h10, 2, 1, 2, 8, 8, 32, -32, 16'h100, 0, 1, 17));
      put_set(5, mk(32'h4000, 32'h5000, 4, 2, 4, 4, 4, 16, 16, 5, 1, 1, 63));
      // R2 R3 R8 R13: array mode, 4 arrays x 3 frames, early completion
      tag = "R2 R3 R8 R13";
      drive(0, 1, 0, 0, 0);
      for (int i = 0; i < 12; i++) begin
         if (i % 3 == 0) kick(2);
         else drive(1, 0, 0, 0, 0);
      end
      idle(2);
      // R4 R9 R12: frame mode, normal completion, negative frame step wraps
      tag = "R4 R9 R12";
      for (int i = 0; i < 3; i++) begin
         kick(2);
         drive(0, 0, 0, 1, 9);
         idle(1);
      end
      // R7: dummy set completes without request and reloads
      tag = "R7";
      kick(2);
      // R6: null set ignored except for its completion
      tag = "R6";
      kick(1);
      kick(2);
      // R11: bind beats a trigger in the same cycle
      tag = "R11";
      drive(1, 1, 4, 0, 0);
      idle(2);
      // R5 R12: wrap past 2^32, then link beyond DEPTH gives the zero set
      tag = "R5 R12";
      kick(1);
      kick(1);
      kick(2);
      // R10: local and returned completion in the same cycle
      tag = "R10";
      drive(0, 1, 5, 0, 0);
      drive(1, 0, 0, 1, 7);
      idle(2);
      drive(1, 0, 0, 1, 12);
      drive(0, 0, 0, 1, 13);
      idle(2);
      // R5: self-linked circular set reloads itself
      tag = "R5";
      for (int i = 0; i < 6; i++) kick(1);
      idle(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule